// File: doc/BRIEF.md
# Receive Completion-Pointer Interrupt Acknowledge

This block holds one completion pointer per receive DMA channel. It drives one interrupt line for each channel. When the DMA engine finishes a buffer, it sends the channel number and the descriptor address of that buffer on a valid/ready stream. The block stores the address and raises the channel's interrupt. The stream's ready is held high at all times, so the block never applies back-pressure, and each cycle with valid high is one completion.

The host services the interrupt through a simple register port. It writes the address of the last descriptor it processed into the channel's slot. That write is never stored. It is only compared with the pointer the DMA side recorded. The interrupt drops when the two are equal and stays up when they differ. A read of a slot always returns the DMA-recorded pointer. A summary interrupt output combines all channels.

Top module: `cp_ack_top`

## Requirements
- R1: After reset every pointer reads 0, every per-channel interrupt is low and the summary interrupt is low.
- R2: `dma_ready` is always 1. A cycle with `dma_valid` high stores `dma_ptr` for channel `dma_ch` and sets that channel's interrupt, which is visible after the next rising clock edge.
- R3: A read with `reg_rd` high returns, one cycle later with `reg_rvalid` high, the pointer the DMA side last stored for the addressed channel.
- R4: A host write is never stored. A later read returns the DMA-stored pointer, not the written data.
- R5: A host write whose data equals the channel's stored pointer clears that channel's interrupt after the next edge.
- R6: A host write whose data differs from the stored pointer leaves the interrupt asserted.
- R7: When a DMA completion and a host write hit the same channel in the same cycle, the DMA update takes effect. The pointer takes the DMA value and the interrupt stays high.
- R8: Channel n's slot is at byte address BASE + 4*n, with BASE = 0 by default. A write to any other address has no effect, and a read of any other address returns 0.
- R9: `irq_any` is high exactly when at least one per-channel interrupt is high.
- R10: A host write to one channel changes no other channel's pointer or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_valid | input | 1 | DMA completion valid |
| dma_ready | output | 1 | Always 1 |
| dma_ch | input | 3 | Completing channel |
| dma_ptr | input | 32 | Descriptor address of the completed buffer |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 8 | Host byte address |
| reg_wdata | input | 32 | Host write data (acknowledge value) |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| irq_ch | output | 8 | Per-channel interrupt |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
The hardest case to reach from the ports is a DMA completion and a host acknowledge landing on the same channel in the same cycle, with the acknowledge data equal to the old pointer. Only that combination tells whether the DMA update takes precedence. The bench first brings the channel to a known pointer. It then drives both strobes in the same cycle, with the host data set to that old pointer. Finally it reads the slot back and checks the interrupt. Misaligned and out-of-range addresses are probed after a channel is left pending, so any stray clear or store would be seen.

// File: rtl/cp_ack_pkg.sv
package cp_ack_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_DMA   = 2'd1,
    UPD_CLEAR = 2'd2
  } slot_upd_e;
endpackage

// File: rtl/cp_addr_dec.sv
module cp_addr_dec #(
  parameter int ADDR_W = 8,
  parameter int NCH    = 8,
  parameter logic [ADDR_W-1:0] BASE = '0,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-3:0] word;

  always_comb begin
    off  = addr - BASE;
    word = off[ADDR_W-1:2];
    hit  = (addr >= BASE) && (off[1:0] == 2'b00) && (32'(word) < 32'(NCH));
    idx  = word[IDX_W-1:0];
  end
endmodule

// File: rtl/cp_slot.sv
module cp_slot
  import cp_ack_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_we,
  input  logic [PTR_W-1:0] dma_ptr,
  input  logic             ack_we,
  input  logic [PTR_W-1:0] ack_val,
  output logic [PTR_W-1:0] ptr,
  output logic             irq
);
  slot_upd_e upd;

  always_comb begin
    if (dma_we)                         upd = UPD_DMA;
    else if (ack_we && ack_val == ptr)  upd = UPD_CLEAR;
    else                                upd = UPD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      irq <= 1'b0;
    end else begin
      case (upd)
        UPD_DMA: begin
          ptr <= dma_ptr;
          irq <= 1'b1;
        end
        UPD_CLEAR: irq <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cp_rd_port.sv
module cp_rd_port #(
  parameter int NCH   = 8,
  parameter int PTR_W = 32,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd,
  input  logic                      hit,
  input  logic [IDX_W-1:0]          idx,
  input  logic [NCH-1:0][PTR_W-1:0] ptrs,
  output logic [PTR_W-1:0]          rdata,
  output logic                      rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= hit ? ptrs[idx] : '0;
    end
  end
endmodule

// File: rtl/cp_ack_top.sv
module cp_ack_top #(
  parameter int NCH    = 8,
  parameter int PTR_W  = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = '0,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic [IDX_W-1:0]  dma_ch,
  input  logic [PTR_W-1:0]  dma_ptr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PTR_W-1:0]  reg_wdata,
  output logic [PTR_W-1:0]  reg_rdata,
  output logic              reg_rvalid,
  output logic [NCH-1:0]    irq_ch,
  output logic              irq_any
);
  logic                      hit;
  logic [IDX_W-1:0]          idx;
  logic [NCH-1:0][PTR_W-1:0] ptrs;

  assign dma_ready = 1'b1;

  cp_addr_dec #(.ADDR_W(ADDR_W), .NCH(NCH), .BASE(BASE)) dec_i (
    .addr(reg_addr), .hit(hit), .idx(idx)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic dma_sel, ack_sel;
    assign dma_sel = dma_valid && (32'(dma_ch) == g);
    assign ack_sel = reg_wr && hit && (32'(idx) == g);
    cp_slot #(.PTR_W(PTR_W)) slot_i (
      .clk(clk), .rst_n(rst_n),
      .dma_we(dma_sel), .dma_ptr(dma_ptr),
      .ack_we(ack_sel), .ack_val(reg_wdata),
      .ptr(ptrs[g]), .irq(irq_ch[g])
    );
  end

  cp_rd_port #(.NCH(NCH), .PTR_W(PTR_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .hit(hit), .idx(idx),
    .ptrs(ptrs), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  assign irq_any = |irq_ch;
endmodule

// File: rtl/cp_ack_chk.sv
module cp_ack_chk #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = '0,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_valid,
  input logic [IDX_W-1:0]  dma_ch,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rvalid,
  input logic [NCH-1:0]    irq_ch,
  input logic              irq_any
);
  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R3

  AST_ANY_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (irq_ch != '0)); // R9

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic hw;
    assign hw = reg_wr && (reg_addr == ADDR_W'(BASE + ADDR_W'(4 * g)));

    AST_DMA_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_valid && 32'(dma_ch) == g) |=> irq_ch[g]); // R2

    AST_FALL_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (hw == 1'b0 && irq_ch[g]) |=> irq_ch[g]); // R5

    AST_COLLIDE_DMA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hw && dma_valid && 32'(dma_ch) == g) |=> irq_ch[g]); // R7
  end
endmodule

bind cp_ack_top cp_ack_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE(BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .dma_valid(dma_valid), .dma_ch(dma_ch),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rvalid(reg_rvalid), .irq_ch(irq_ch), .irq_any(irq_any)
);

// File: tb/cp_ack_top_tb_top.sv
module cp_ack_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_valid = 1'b0;
  logic        dma_ready;
  logic [2:0]  dma_ch = '0;
  logic [31:0] dma_ptr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [7:0]  irq_ch;
  logic        irq_any;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_ptr [8];
  logic [7:0]  exp_irq;

  always #4 clk = ~clk;

  cp_ack_top dut_i (
    .clk(clk), .rst_n(rst_n), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_ch(dma_ch), .dma_ptr(dma_ptr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_ch(irq_ch), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dma_wr(input int ch, input logic [31:0] v);
    dma_valid = 1'b1; dma_ch = 3'(ch); dma_ptr = v;
    @(negedge clk);
    dma_valid = 1'b0;
    exp_ptr[ch] = v; exp_irq[ch] = 1'b1;
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R3 rvalid", 32'(reg_rvalid), 32'd1);
    v = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq_ch", 32'(irq_ch), 32'd0);
    chk("R1 irq_any", 32'(irq_any), 32'd0);
    for (int c = 0; c < 8; c++) begin
      host_rd(8'(4 * c), v);
      chk("R1 ptr", v, 32'd0);
    end
    chk("R2 ready", 32'(dma_ready), 32'd1);
  endtask

  task automatic t_dma_read;
    logic [31:0] v;
    dma_wr(3, 32'h1000_0040);
    chk("R2 irq raised", 32'(irq_ch), 32'(exp_irq));
    chk("R9 any", 32'(irq_any), 32'd1);
    host_rd(8'h0C, v);
    chk("R3 read ptr", v, 32'h1000_0040);
  endtask

  task automatic t_mismatch_not_stored;
    logic [31:0] v;
    host_wr(8'h0C, 32'hDEAD_BEEF);
    chk("R6 irq held", 32'(irq_ch), 32'(exp_irq));
    host_rd(8'h0C, v);
    chk("R4 not stored", v, 32'h1000_0040);
  endtask

  task automatic t_match_clear;
    dma_wr(5, 32'h2222_0000);
    host_wr(8'h0C, 32'h1000_0040);
    exp_irq[3] = 1'b0;
    chk("R5 ch3 cleared", 32'(irq_ch), 32'(exp_irq));
    chk("R10 ch5 intact", 32'(irq_ch[5]), 32'd1);
    chk("R9 any", 32'(irq_any), 32'd1);
    host_wr(8'h14, 32'h2222_0000);
    exp_irq[5] = 1'b0;
    chk("R5 ch5 cleared", 32'(irq_ch), 32'(exp_irq));
    chk("R9 none", 32'(irq_any), 32'd0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    dma_wr(6, 32'h0000_0A00);
    dma_valid = 1'b1; dma_ch = 3'd6; dma_ptr = 32'h0000_0B00;
    reg_wr = 1'b1; reg_addr = 8'h18; reg_wdata = 32'h0000_0A00;
    @(negedge clk);
    dma_valid = 1'b0; reg_wr = 1'b0;
    exp_ptr[6] = 32'h0000_0B00;
    chk("R7 irq stays", 32'(irq_ch[6]), 32'd1);
    host_rd(8'h18, v);
    chk("R7 dma value", v, 32'h0000_0B00);
    host_wr(8'h18, 32'h0000_0B00);
    exp_irq[6] = 1'b0;
    chk("R5 after collide", 32'(irq_ch[6]), 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    dma_wr(0, 32'h0000_0010);
    host_wr(8'h01, 32'h0000_0010);
    chk("R8 misaligned ignored", 32'(irq_ch[0]), 32'd1);
    host_wr(8'h20, 32'h0000_0010);
    chk("R8 out of range ignored", 32'(irq_ch[0]), 32'd1);
    host_rd(8'h20, v);
    chk("R8 unmapped reads 0", v, 32'd0);
    host_rd(8'h02, v);
    chk("R8 misaligned reads 0", v, 32'd0);
    host_rd(8'h00, v);
    chk("R8 ch0 intact", v, 32'h0000_0010);
  endtask

  task automatic t_all_channels;
    logic [31:0] v;
    for (int c = 0; c < 8; c++) dma_wr(c, 32'hC000_0000 + 32'(c * 16));
    chk("R2 all raised", 32'(irq_ch), 32'hFF);
    for (int c = 0; c < 8; c++) begin
      host_rd(8'(4 * c), v);
      chk("R3 per-channel read", v, exp_ptr[c]);
    end
    for (int c = 0; c < 8; c++) begin
      host_wr(8'(4 * c), exp_ptr[c]);
      exp_irq[c] = 1'b0;
      chk("R10 one at a time", 32'(irq_ch), 32'(exp_irq));
    end
    chk("R9 all clear", 32'(irq_any), 32'd0);
  endtask

  initial begin
    fork
      begin
        exp_irq = '0;
        for (int c = 0; c < 8; c++) exp_ptr[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dma_read();
        t_mismatch_not_stored();
        t_match_clear();
        t_collision();
        t_unmapped();
        t_all_channels();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule